// File: doc/BRIEF.md
# CAN Operating-Mode and Wakeup Sequencer

This block decides which operating mode a CAN peripheral is in. Software drives a configuration request bit and the block answers with a configuration acknowledge. Only while that acknowledge is high may the bit-timing setup be changed. Software also sets a power-down request bit. The block grants power-down with an acknowledge only after any frame that is being sent has finished, whether it succeeded, lost arbitration or ended in a bus error. Software must see that acknowledge before it stops the clocks.

While the block is asleep it watches the raw receive level. A dominant level raises a sticky wakeup interrupt flag. If automatic wakeup is enabled, the same event clears the power-down request in hardware. If it is not enabled, software clears the request itself. Either way the block then counts consecutive recessive bits, using a bit-time strobe from the bit-timing logic. It reports bus-active only after a full run of idle bits. This means the frame that caused the wakeup is never received. The error counters are outside this block and are not touched by any of this.

Top module: `can_mode_seq`

## Requirements
- R1: During and right after reset, the configuration acknowledge is 1. Power-down acknowledge, power-down request, the wakeup flag and bus-active are all 0.
- R2: In configuration mode, a low configuration request makes the configuration acknowledge 0 and bus-active 1 one clock later.
- R3: While bus-active, a high configuration request makes the configuration acknowledge 1 and bus-active 0 one clock later.
- R4: When the power-down request register becomes 1 with no frame in flight, the power-down acknowledge goes to 1 one clock later and bus-active goes to 0.
- R5: A frame is in flight from its start strobe until a done, arbitration-lost or bus-error strobe. While it is in flight, the power-down acknowledge stays 0. It goes to 1 on the clock after the ending strobe.
- R6: A 0 (dominant) receive level during power-down sets the wakeup flag. The flag holds until a clear strobe (write-one) arrives. A set on the same clock wins over the clear.
- R7: With automatic wakeup enabled, a dominant level during power-down clears both the power-down request and the power-down acknowledge on the next clock.
- R8: With automatic wakeup disabled, a dominant level during power-down sets the wakeup flag but leaves the request and the acknowledge at 1. A software write of 0 to the request drops the acknowledge two clocks after the write.
- R9: After leaving power-down, bus-active rises on the clock after the 11th consecutive bit strobe that samples recessive (1). A dominant sample on a bit strobe restarts the count from zero, and cycles without a bit strobe are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req_i | input | 1 | Configuration-mode request control bit (level) |
| pdr_we_i | input | 1 | Software write strobe for the power-down request bit |
| pdr_wd_i | input | 1 | Value written to the power-down request bit |
| wake_en_i | input | 1 | Automatic wakeup on bus activity enable |
| rx_i | input | 1 | Receive line level, 0 = dominant |
| bit_tick_i | input | 1 | One-cycle strobe per nominal bit time |
| tx_start_i | input | 1 | Transmitter begins a frame |
| tx_done_i | input | 1 | Frame sent successfully |
| tx_arb_lost_i | input | 1 | Frame lost arbitration |
| tx_err_i | input | 1 | Frame ended with a bus error |
| wuif_clr_i | input | 1 | Write-one clear of the wakeup flag |
| cfg_ack_o | output | 1 | Configuration mode confirmed |
| pd_ack_o | output | 1 | Power-down granted |
| pdr_o | output | 1 | Current power-down request bit |
| wuif_o | output | 1 | Sticky wakeup interrupt flag |
| bus_active_o | output | 1 | Node takes part in bus traffic |

## Verification
The bench raises the power-down request in the middle of a frame and ends the frame in each of the three possible ways. A design that granted power-down at once would cut a frame short and corrupt the bus. During resynchronisation it places a dominant bit strobe after a partial recessive run, and it sends recessive levels on cycles with no strobe. An off-by-one count, or a count that does not restart, would show up as bus-active rising too early. It also covers wakeup with automatic clearing disabled and the software-clear exit. A design that cleared the request in hardware in that case would leave sleep without software asking for it.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    localparam int unsigned RESYNC_BITS_DEFAULT = 11;

    typedef enum logic [1:0] {
        MODE_CONFIG = 2'd0,
        MODE_ACTIVE = 2'd1,
        MODE_SLEEP  = 2'd2,
        MODE_RESYNC = 2'd3
    } mode_e;

    typedef struct packed {
        logic cfg_ack;
        logic pd_ack;
        logic bus_active;
    } mode_status_t;

    function automatic mode_status_t decode_status(mode_e m);
        mode_status_t s;
        s.cfg_ack    = (m == MODE_CONFIG);
        s.pd_ack     = (m == MODE_SLEEP);
        s.bus_active = (m == MODE_ACTIVE);
        return s;
    endfunction

endpackage

// File: rtl/can_mode_txtrack.sv
module can_mode_txtrack (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic end_i,
    output logic busy_o
);
    logic busy_q;

    always_ff @(posedge clk) begin
        if (rst)          busy_q <= 1'b0;
        else if (end_i)   busy_q <= 1'b0;
        else if (start_i) busy_q <= 1'b1;
    end

    assign busy_o = busy_q;
endmodule

// File: rtl/can_mode_idlecnt.sv
module can_mode_idlecnt #(
    parameter int unsigned RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic tick_i,
    input  logic rx_i,
    output logic done_o
);
    localparam int unsigned CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) cnt_q <= '0;
        else if (tick_i) begin
            if (!rx_i)              cnt_q <= '0;
            else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = run_i && tick_i && rx_i && (cnt_q == LAST);
endmodule

// File: rtl/can_mode_flags.sv
module can_mode_flags (
    input  logic clk,
    input  logic rst,
    input  logic pdr_we_i,
    input  logic pdr_wd_i,
    input  logic pdr_hw_clr_i,
    input  logic wu_set_i,
    input  logic wu_clr_i,
    output logic pdr_o,
    output logic wuif_o
);
    logic pdr_q;
    logic wuif_q;

    always_ff @(posedge clk) begin
        if (rst)               pdr_q <= 1'b0;
        else if (pdr_hw_clr_i) pdr_q <= 1'b0;
        else if (pdr_we_i)     pdr_q <= pdr_wd_i;
    end

    always_ff @(posedge clk) begin
        if (rst)           wuif_q <= 1'b0;
        else if (wu_set_i) wuif_q <= 1'b1;
        else if (wu_clr_i) wuif_q <= 1'b0;
    end

    assign pdr_o  = pdr_q;
    assign wuif_o = wuif_q;
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
    import can_mode_pkg::*;
#(
    parameter int unsigned RESYNC_BITS = RESYNC_BITS_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_req_i,
    input  logic pdr_we_i,
    input  logic pdr_wd_i,
    input  logic wake_en_i,
    input  logic rx_i,
    input  logic bit_tick_i,
    input  logic tx_start_i,
    input  logic tx_done_i,
    input  logic tx_arb_lost_i,
    input  logic tx_err_i,
    input  logic wuif_clr_i,
    output logic cfg_ack_o,
    output logic pd_ack_o,
    output logic pdr_o,
    output logic wuif_o,
    output logic bus_active_o
);
    mode_e        mode_q, mode_d;
    mode_status_t stat;
    logic         tx_end_w;
    logic         in_flight_w;
    logic         resync_done_w;
    logic         pdr_w;
    logic         wake_evt_w;
    logic         auto_clr_w;

    assign tx_end_w   = tx_done_i | tx_arb_lost_i | tx_err_i;
    assign wake_evt_w = (mode_q == MODE_SLEEP) && !rx_i;
    assign auto_clr_w = wake_evt_w && wake_en_i;

    can_mode_txtrack u_txtrack (
        .clk     (clk),
        .rst     (rst),
        .start_i (tx_start_i),
        .end_i   (tx_end_w),
        .busy_o  (in_flight_w)
    );

    can_mode_idlecnt #(.RUN_LEN(RESYNC_BITS)) u_idlecnt (
        .clk    (clk),
        .rst    (rst),
        .run_i  (mode_q == MODE_RESYNC),
        .tick_i (bit_tick_i),
        .rx_i   (rx_i),
        .done_o (resync_done_w)
    );

    can_mode_flags u_flags (
        .clk          (clk),
        .rst          (rst),
        .pdr_we_i     (pdr_we_i),
        .pdr_wd_i     (pdr_wd_i),
        .pdr_hw_clr_i (auto_clr_w),
        .wu_set_i     (wake_evt_w),
        .wu_clr_i     (wuif_clr_i),
        .pdr_o        (pdr_w),
        .wuif_o       (wuif_o)
    );

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_CONFIG: if (!cfg_req_i) mode_d = MODE_ACTIVE;
            MODE_ACTIVE: begin
                if (cfg_req_i)
                    mode_d = MODE_CONFIG;
                else if (pdr_w && (!in_flight_w || tx_end_w))
                    mode_d = MODE_SLEEP;
            end
            MODE_SLEEP: begin
                if (auto_clr_w || !pdr_w) mode_d = MODE_RESYNC;
            end
            MODE_RESYNC: begin
                if (cfg_req_i)          mode_d = MODE_CONFIG;
                else if (resync_done_w) mode_d = MODE_ACTIVE;
            end
            default: mode_d = MODE_CONFIG;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_CONFIG;
        else     mode_q <= mode_d;
    end

    assign stat         = decode_status(mode_q);
    assign cfg_ack_o    = stat.cfg_ack;
    assign pd_ack_o     = stat.pd_ack;
    assign bus_active_o = stat.bus_active;
    assign pdr_o        = pdr_w;
endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk (
    input logic clk,
    input logic rst,
    input logic cfg_ack,
    input logic pd_ack,
    input logic pdr,
    input logic wuif,
    input logic bus_active,
    input logic rx,
    input logic wake_en,
    input logic tick,
    input logic wuif_clr,
    input logic tx_busy,
    input logic tx_end
);
    // R4
    sleep_not_active_chk: assert property (@(posedge clk) disable iff (rst)
        pd_ack |-> !bus_active);

    // R2
    cfg_exit_active_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_ack) |-> bus_active);

    // R5
    hold_during_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (!pd_ack && tx_busy && !tx_end) |=> !pd_ack);

    // R6
    wuif_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (wuif && !wuif_clr) |=> wuif);

    // R7
    auto_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (pd_ack && !rx && wake_en) |=> (!pdr && !pd_ack && wuif));

    // R9
    resync_end_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_active) && !$past(cfg_ack)) |-> $past(tick && rx));
endmodule

bind can_mode_seq can_mode_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_ack    (cfg_ack_o),
    .pd_ack     (pd_ack_o),
    .pdr        (pdr_o),
    .wuif       (wuif_o),
    .bus_active (bus_active_o),
    .rx         (rx_i),
    .wake_en    (wake_en_i),
    .tick       (bit_tick_i),
    .wuif_clr   (wuif_clr_i),
    .tx_busy    (in_flight_w),
    .tx_end     (tx_end_w)
);

// File: tb/sim_can_mode_seq.sv
`timescale 1ns/1ps
module sim_can_mode_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_req = 1'b1, pdr_we = 1'b0, pdr_wd = 1'b0, wake_en = 1'b0;
    logic rx = 1'b1, tick = 1'b0, tx_start = 1'b0, tx_done = 1'b0;
    logic tx_arb = 1'b0, tx_err = 1'b0, wuif_clr = 1'b0;
    logic cfg_ack, pd_ack, pdr, wuif, bus_active;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    can_mode_seq u0 (
        .clk(clk), .rst(rst), .cfg_req_i(cfg_req), .pdr_we_i(pdr_we),
        .pdr_wd_i(pdr_wd), .wake_en_i(wake_en), .rx_i(rx), .bit_tick_i(tick),
        .tx_start_i(tx_start), .tx_done_i(tx_done), .tx_arb_lost_i(tx_arb),
        .tx_err_i(tx_err), .wuif_clr_i(wuif_clr), .cfg_ack_o(cfg_ack),
        .pd_ack_o(pd_ack), .pdr_o(pdr), .wuif_o(wuif), .bus_active_o(bus_active)
    );

    // inputs: cfg,we,wd,wen,rx,tick,start,done,clr | expect: cack,pack,pdr,wuif,bus
    localparam int NV = 13;
    localparam logic [13:0] VEC [0:NV-1] = '{
        14'b000010000_00001,  // R2 leave configuration
        14'b000010100_00001,  // R5 frame starts
        14'b011010000_00101,  // R5 request during frame
        14'b000010000_00101,  // R5 still waiting
        14'b000010000_00101,  // R5 still waiting
        14'b000010010_01100,  // R5 frame done -> granted
        14'b000110000_01100,  // R7 recessive, stay asleep
        14'b000100000_00010,  // R7 dominant wakes
        14'b000101000_00010,  // R9 dominant tick
        14'b000111000_00010,  // R9 recessive tick
        14'b000110000_00010,  // R9 no tick
        14'b000111000_00010,  // R9 recessive tick
        14'b000101000_00010   // R9 dominant restarts count
    };

    function automatic string tag_of(int i);
        if (i == 0) return "R2";
        if (i < 6)  return "R5";
        if (i < 8)  return "R7";
        return "R9";
    endfunction

    task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {cfg_ack, pd_ack, pdr, wuif, bus_active};
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        pdr_we = 1'b0; tick = 1'b0; tx_start = 1'b0; tx_done = 1'b0;
        tx_arb = 1'b0; tx_err = 1'b0; wuif_clr = 1'b0;
    endtask

    task automatic resync_run(string req);
        rx = 1'b1;
        for (int k = 0; k < 10; k++) begin
            tick = 1'b1; step();
        end
        chk(req, {4'b0, bus_active}, 5'b0);
        tick = 1'b1; step();
        chk(req, {4'b0, bus_active}, 5'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 in reset", outs(), 5'b10000);
        rst = 1'b0;
        step();
        chk("R1 after reset", outs(), 5'b10000);

        for (int i = 0; i < NV; i++) begin
            {cfg_req, pdr_we, pdr_wd, wake_en, rx, tick, tx_start, tx_done, wuif_clr} = VEC[i][13:5];
            step();
            chk(tag_of(i), outs(), VEC[i][4:0]);
        end

        // R9: full recessive run after restart
        resync_run("R9 eleven ticks");

        // R6: flag sticky, then cleared by write-one
        step();
        chk("R6 sticky", {4'b0, wuif}, 5'b1);
        wuif_clr = 1'b1; step();
        chk("R6 cleared", {4'b0, wuif}, 5'b0);

        // R3: back to configuration and out again
        cfg_req = 1'b1; step();
        chk("R3 enter cfg", outs(), 5'b10000);
        cfg_req = 1'b0; step();
        chk("R2 leave cfg", outs(), 5'b00001);

        // R5: arbitration-lost ends the frame
        wake_en = 1'b0;
        tx_start = 1'b1; step();
        pdr_we = 1'b1; pdr_wd = 1'b1; step();
        step();
        chk("R5 arb wait", outs(), 5'b00101);
        tx_arb = 1'b1; step();
        chk("R5 arb grant", outs(), 5'b01100);

        // R8: wakeup with auto-clear disabled
        rx = 1'b0; step();
        rx = 1'b1;
        chk("R8 flag only", outs(), 5'b01110);
        step();
        chk("R8 stays asleep", outs(), 5'b01110);
        pdr_we = 1'b1; pdr_wd = 1'b0; step();
        chk("R8 pdr cleared", outs(), 5'b01010);
        step();
        chk("R8 ack drops", outs(), 5'b00010);
        resync_run("R9 after sw exit");
        wuif_clr = 1'b1; step();

        // R5: bus error ends the frame
        tx_start = 1'b1; step();
        pdr_we = 1'b1; pdr_wd = 1'b1; step();
        chk("R5 err wait", outs(), 5'b00101);
        tx_err = 1'b1; step();
        chk("R5 err grant", outs(), 5'b01100);
        pdr_we = 1'b1; pdr_wd = 1'b0; step();
        step();
        resync_run("R9 third run");

        // R4: request with no frame in flight
        pdr_we = 1'b1; pdr_wd = 1'b1; step();
        chk("R4 request seen", outs(), 5'b00101);
        step();
        chk("R4 granted", outs(), 5'b01100);

        // R1: reset again from sleep
        rst = 1'b1; cfg_req = 1'b1; step();
        chk("R1 reset from sleep", outs(), 5'b10000);
        rst = 1'b0;

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule